// File: doc/BRIEF.md
# Sectioned Write-Protected Word Store

This block is the synchronous front end of a single-port word store that is 16 bits wide and addressed by 16 bits. A rising chip-select strobe, sampled on the system clock, captures the address and the write request into holding registers. Everything that follows in the access works from those held values: choosing the operating mode, checking protection, steering the data bus and committing the write.

The address space is split into a lower half and an upper half. Each half has its own active-low write-inhibit input. Software can therefore treat one half as writable memory and the other as read-only contents, and swap those roles at run time. A separate write-go input can hold back the start of a captured write until the surrounding system is ready. A write that lands on an inhibited half is dropped, and the block reports it with a single-cycle rejection pulse. The data bus is split into an input, an output and an output-enable, which together stand for a tri-state pin.

The storage depth is a parameter. The array index is taken from the low address bits, so a shallow array repeats (aliases) across the address space. The half is still chosen by the top address bit.

Top module: `sect_mem_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no strobe yet seen, `dq_en` and `wr_reject` are both 0.
- R2: The address and `we` are captured on the first clock edge at which `cs` is sampled high after being sampled low. Later changes to `addr` or `we` while `cs` stays high change neither the driven word nor the stored contents.
- R3: The top address bit picks the half. A value of 0 (0x0000 to 0x7FFF) is guarded by `wi_n[0]`, and a value of 1 (0x8000 to 0xFFFF) is guarded by `wi_n[1]`.
- R4: While the guard bit for the captured address is 0, the block is deselected and `dq_en` is 0, whatever the values of `we` and `oe`.
- R5: With the guard high, captured `we`=0 and `oe`=1, `dq_en` is 1 and `dq_o` carries the stored word, starting right after the capturing clock edge.
- R6: With the guard high, captured `we`=0 and `oe`=0, `dq_en` is 0.
- R7: With the guard high and captured `we`=1, the word on `dq_i` is stored at the commit edge, and `dq_en` stays 0 whatever the value of `oe`.
- R8: A captured write stays pending, and neither writes nor rejects, until a clock edge at which `we_go` is 1. That edge is the commit edge, and it may come after `cs` has fallen.
- R9: At a commit edge where the guard bit for the captured address is 0, the stored word is left unchanged and `wr_reject` is 1 for exactly the following clock cycle.
- R10: Read data on `dq_o` holds until the next capture. Dropping `oe` clears `dq_en` in the same cycle, and raising `oe` again restores the same word.
- R11: The array word is selected by `addr[IDX_W-1:0]`. Addresses that differ only above that field share one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip-select strobe; its sampled rising edge starts an access |
| addr | input | ADDR_W | Word address |
| we | input | 1 | Write request, captured with the address |
| we_go | input | 1 | Write-go; a pending write commits at an edge where this is 1 |
| oe | input | 1 | Output enable for reads |
| wi_n | input | 2 | Active-low write inhibit; bit 0 lower half, bit 1 upper half |
| dq_i | input | DATA_W | Write data from the bus |
| dq_o | output | DATA_W | Read data toward the bus |
| dq_en | output | 1 | Bus drive enable (1 = block drives `dq_o`) |
| wr_reject | output | 1 | One-cycle pulse for a write dropped by protection |

## Verification
The bench keeps the default 16-bit address and data widths but builds the store with `IDX_W`=8. This gives 256 words, so a preload pass can fill the whole array and every later read has a known value. Random addresses over the full 16-bit space exercise both halves and the aliasing above bit 7. Directed sequences cover the cases random accesses rarely reach: a write held back by `we_go` across the fall of `cs`, a delayed write that is then rejected, the boundary words 0x7FFF and 0x8000 under each inhibit pattern, and changes to the inputs after capture.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [1:0] {
    MODE_DESEL = 2'd0,
    MODE_OFF   = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } mode_e;
endpackage

// File: rtl/smc_mode_dec.sv
module smc_mode_dec
  import smc_pkg::*;
(
  input  logic  sel,
  input  logic  wr_ok,
  input  logic  we_l,
  input  logic  oe,
  output mode_e mode
);
  always_comb begin
    if (!sel || !wr_ok)  mode = MODE_DESEL;
    else if (we_l)       mode = MODE_WRITE;
    else if (oe)         mode = MODE_READ;
    else                 mode = MODE_OFF;
  end
endmodule

// File: rtl/smc_store.sv
module smc_store #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q, rd_nxt;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_comb begin
    rd_nxt = rd_q;
    if (rd_en) rd_nxt = mem[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_nxt;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/smc_wr_ctrl.sv
module smc_wr_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic cap_we,
  input  logic we_go,
  input  logic wr_ok,
  output logic commit,
  output logic reject
);
  logic pend_q, pend_nxt;
  logic rej_q, rej_nxt;
  logic attempt;

  assign attempt = pend_q && we_go;
  assign commit  = attempt && wr_ok;

  always_comb begin
    pend_nxt = pend_q;
    if (capture)      pend_nxt = cap_we;
    else if (attempt) pend_nxt = 1'b0;
    rej_nxt = attempt && !wr_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      rej_q  <= rej_nxt;
    end
  end

  assign reject = rej_q;

  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !we_go && !capture) |=> pend_q);

  // R9
  reject_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> !reject);
endmodule

// File: rtl/sect_mem_ctrl.sv
module sect_mem_ctrl
  import smc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              we_go,
  input  logic              oe,
  input  logic [1:0]        wi_n,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_en,
  output logic              wr_reject
);
  localparam int HALF_BIT = ADDR_W - 1;

  logic              cs_q, cs_nxt;
  logic              sel_q, sel_nxt;
  logic [ADDR_W-1:0] lat_addr, lat_addr_nxt;
  logic              lat_we, lat_we_nxt;
  logic              capture;
  logic              region_l;
  logic              wr_ok;
  logic              commit;
  mode_e             mode;

  assign capture  = cs && !cs_q;
  assign region_l = lat_addr[HALF_BIT];
  assign wr_ok    = wi_n[region_l];

  always_comb begin
    cs_nxt       = cs;
    sel_nxt      = sel_q;
    lat_addr_nxt = lat_addr;
    lat_we_nxt   = lat_we;
    if (capture) begin
      sel_nxt      = 1'b1;
      lat_addr_nxt = addr;
      lat_we_nxt   = we;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b0;
      sel_q    <= 1'b0;
      lat_addr <= '0;
      lat_we   <= 1'b0;
    end else begin
      cs_q     <= cs_nxt;
      sel_q    <= sel_nxt;
      lat_addr <= lat_addr_nxt;
      lat_we   <= lat_we_nxt;
    end
  end

  smc_mode_dec u_mode (
    .sel   (sel_q),
    .wr_ok (wr_ok),
    .we_l  (lat_we),
    .oe    (oe),
    .mode  (mode)
  );

  smc_wr_ctrl u_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .cap_we  (we),
    .we_go   (we_go),
    .wr_ok   (wr_ok),
    .commit  (commit),
    .reject  (wr_reject)
  );

  smc_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (capture),
    .rd_idx  (addr[IDX_W-1:0]),
    .wr_en   (commit),
    .wr_idx  (lat_addr[IDX_W-1:0]),
    .wr_data (dq_i),
    .rd_data (dq_o)
  );

  assign dq_en = (mode == MODE_READ);

  // R2
  capture_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (lat_addr == $past(addr)) && (lat_we == $past(we)));

  // R4
  lock_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && !wi_n[lat_addr[HALF_BIT]]) |-> !dq_en);

  // R6
  oe_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !dq_en);

  // R7
  write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_we |-> !dq_en);

  // R10
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_en && !capture) |=> $stable(dq_o));
endmodule

// File: tb/sect_mem_ctrl_test.sv
module sect_mem_ctrl_test;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cs, we, we_go, oe;
  logic [AW-1:0] addr;
  logic [1:0]    wi_n;
  logic [DW-1:0] dq_i;
  logic [DW-1:0] dq_o;
  logic          dq_en, wr_reject;

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] mdl [1<<IW];

  always #10 clk = ~clk;

  sect_mem_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .we(we), .we_go(we_go),
    .oe(oe), .wi_n(wi_n), .dq_i(dq_i), .dq_o(dq_o), .dq_en(dq_en),
    .wr_reject(wr_reject)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic guard_ok(input logic [AW-1:0] a, input logic [1:0] wi);
    return wi[a[AW-1]];
  endfunction

  function automatic logic [DW-1:0] fill_val(input int i);
    return DW'(i * 16'h9E37 + 16'h0A5);
  endfunction

  // One complete access: capture, check drive, commit edge, check pulse, release.
  task automatic access(input logic [AW-1:0] a, input logic w, input logic o,
                        input logic [1:0] wi, input logic [DW-1:0] d, input string tag);
    logic ok, exp_en;
    logic [IW-1:0] ix;
    ok = guard_ok(a, wi);
    ix = a[IW-1:0];
    @(negedge clk);
    addr = a; we = w; oe = o; wi_n = wi; dq_i = d; we_go = 1'b1; cs = 1'b1;
    @(negedge clk);
    exp_en = ok && !w && o;
    chk({tag, " dq_en"}, {31'd0, dq_en}, {31'd0, exp_en});
    if (exp_en) chk({tag, " dq_o"}, {16'd0, dq_o}, {16'd0, mdl[ix]});
    @(negedge clk);
    chk({tag, " wr_reject"}, {31'd0, wr_reject}, {31'd0, (w && !ok)});
    if (w && ok) mdl[ix] = d;
    cs = 1'b0;
    @(negedge clk);
    chk({tag, " wr_reject low"}, {31'd0, wr_reject}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    rst_n = 1'b0; cs = 1'b0; we = 1'b0; we_go = 1'b0; oe = 1'b0;
    addr = '0; wi_n = 2'b11; dq_i = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 dq_en in reset", {31'd0, dq_en}, 32'd0);
    chk("R1 wr_reject in reset", {31'd0, wr_reject}, 32'd0);
    rst_n = 1'b1;
    oe = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 dq_en idle", {31'd0, dq_en}, 32'd0);
    chk("R1 wr_reject idle", {31'd0, wr_reject}, 32'd0);

    // Preload all words (R7)
    for (int i = 0; i < (1 << IW); i++)
      access({i[0], 7'd0, i[7:0]}, 1'b1, 1'b0, 2'b11, fill_val(i), "R7 preload");

    // R5 read back a few
    access(16'h0003, 1'b0, 1'b1, 2'b11, 16'h0, "R5 read");
    access(16'h80FE, 1'b0, 1'b1, 2'b11, 16'h0, "R5 read");
    // R6 oe low
    access(16'h0004, 1'b0, 1'b0, 2'b11, 16'h0, "R6 disabled");
    // R7 write with oe high still not driven
    access(16'h0011, 1'b1, 1'b1, 2'b11, 16'h5A5A, "R7 write oe high");
    access(16'h0011, 1'b0, 1'b1, 2'b11, 16'h0, "R7 readback");

    // R3 boundary words under each inhibit pattern
    access(16'h7FFF, 1'b1, 1'b0, 2'b10, 16'h1111, "R3 R9 low half locked");
    access(16'h8000, 1'b1, 1'b0, 2'b10, 16'h2222, "R3 high half open");
    access(16'h7FFF, 1'b1, 1'b0, 2'b01, 16'h3333, "R3 low half open");
    access(16'h8000, 1'b1, 1'b0, 2'b01, 16'h4444, "R3 R9 high half locked");
    access(16'h7FFF, 1'b0, 1'b1, 2'b11, 16'h0, "R3 readback FF");
    access(16'h8000, 1'b0, 1'b1, 2'b11, 16'h0, "R3 readback 00");
    // R4 read of locked half not driven
    access(16'h8123, 1'b0, 1'b1, 2'b01, 16'h0, "R4 locked read");

    // R11 alias: write 0x0005, read via 0x2305
    access(16'h0005, 1'b1, 1'b0, 2'b11, 16'hC0DE, "R11 write");
    @(negedge clk);
    addr = 16'h2305; we = 1'b0; oe = 1'b1; wi_n = 2'b11; cs = 1'b1;
    @(negedge clk);
    chk("R11 alias read", {16'd0, dq_o}, 32'h0000C0DE);
    cs = 1'b0;
    @(negedge clk);

    // R2 inputs changed after capture
    @(negedge clk);
    addr = 16'h0040; we = 1'b0; oe = 1'b1; wi_n = 2'b11; cs = 1'b1; dq_i = 16'h0;
    @(negedge clk);
    addr = 16'h0041; we = 1'b1; dq_i = 16'h1234;
    repeat (3) @(negedge clk);
    chk("R2 dq_en after input change", {31'd0, dq_en}, 32'd1);
    chk("R2 dq_o after input change", {16'd0, dq_o}, {16'd0, mdl[8'h40]});
    cs = 1'b0; we = 1'b0;
    @(negedge clk);
    access(16'h0041, 1'b0, 1'b1, 2'b11, 16'h0, "R2 no stray write");

    // R10 oe drop and restore
    @(negedge clk);
    addr = 16'h0030; we = 1'b0; oe = 1'b1; wi_n = 2'b11; cs = 1'b1;
    @(negedge clk);
    chk("R10 read", {16'd0, dq_o}, {16'd0, mdl[8'h30]});
    oe = 1'b0; #1;
    chk("R10 oe low drops drive", {31'd0, dq_en}, 32'd0);
    @(negedge clk);
    oe = 1'b1; #1;
    chk("R10 oe restore drive", {31'd0, dq_en}, 32'd1);
    chk("R10 oe restore data", {16'd0, dq_o}, {16'd0, mdl[8'h30]});
    @(negedge clk);
    cs = 1'b0;
    @(negedge clk);

    // R8 delayed write, commits after cs falls
    addr = 16'h0010; we = 1'b1; we_go = 1'b0; oe = 1'b1; wi_n = 2'b11;
    dq_i = 16'hBEEF; cs = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 held no drive", {31'd0, dq_en}, 32'd0);
    chk("R8 held no reject", {31'd0, wr_reject}, 32'd0);
    cs = 1'b0;
    repeat (2) @(negedge clk);
    we_go = 1'b1;
    @(negedge clk);
    chk("R8 commit no reject", {31'd0, wr_reject}, 32'd0);
    mdl[8'h10] = 16'hBEEF;
    access(16'h0010, 1'b0, 1'b1, 2'b11, 16'h0, "R8 delayed readback");

    // R9 delayed write into locked half
    @(negedge clk);
    addr = 16'h8020; we = 1'b1; we_go = 1'b0; wi_n = 2'b01; dq_i = 16'hDEAD; cs = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 no reject before go", {31'd0, wr_reject}, 32'd0);
    cs = 1'b0; we_go = 1'b1;
    @(negedge clk);
    chk("R9 delayed reject pulse", {31'd0, wr_reject}, 32'd1);
    @(negedge clk);
    chk("R9 pulse one cycle", {31'd0, wr_reject}, 32'd0);
    access(16'h8020, 1'b0, 1'b1, 2'b11, 16'h0, "R9 word unchanged");

    // Random mix
    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] ra;
      logic rw, ro;
      logic [1:0] rwi;
      ra  = AW'($urandom);
      rw  = 1'($urandom);
      ro  = 1'($urandom);
      rwi = 2'($urandom);
      if (!guard_ok(ra, rwi))   access(ra, rw, ro, rwi, DW'($urandom), "R4 R9 random locked");
      else if (rw)              access(ra, rw, ro, rwi, DW'($urandom), "R7 R11 random write");
      else if (ro)              access(ra, rw, ro, rwi, DW'($urandom), "R5 R11 random read");
      else                      access(ra, rw, ro, rwi, DW'($urandom), "R6 random off");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule